// File: doc/BRIEF.md
# Multi-Mode General-Purpose Timer

This block is a down-counting timer built from two 16-bit counter lanes. A single configuration pin decides how the lanes are used. With the pin low, the two lanes are joined into one 32-bit counter that runs one-shot, periodic, or as a real-time counter that steps up on an external once-per-second strobe. With the pin high, each lane runs on its own. Each lane can then run one-shot or periodic with an 8-bit prescaler in front of it, latch its count on a selected edge of an input pin, or drive a PWM output from a comparison against a match value.

All configuration and write strobes are plain synchronous pins. The block has no streaming data path, so it has no valid/ready handshake. Each lane has three sticky event flags that are cleared by write-one-to-clear strobes. Any time-out also raises a one-cycle pulse that can start an external analog-to-digital conversion.

Top module: `gp_timer`

## Requirements
- R1: After reset, every count, load, match, capture and prescale register is zero. All flags are clear, both lanes are stopped, and `pwm_o` and `adc_trig_o` are low.
- R2: A load strobe writes the load register and the counter, and the new value is visible on `count_o` in the next cycle. In joined mode (`split_i`=0), `load_we_i[0]` loads `{load_val_i[1],load_val_i[0]}` into both lanes. `match_we_i[0]` writes the match value across both lanes in the same way.
- R3: In split mode, a running lane with prescale value P decrements once every P+1 cycles. The first step comes P+1 cycles after the load or enable. A load also restarts the prescaler.
- R4: One-shot (lane mode 2'b00, or joined mode `mode32_i`=2'b00): on the step after the count reaches zero, the timer sets the time-out flag (bit 0), clears the lane's enable, and holds the count at zero.
- R5: Periodic (lane mode 2'b01, or joined mode 2'b01): on the step after the count reaches zero, the timer sets the time-out flag and reloads the count from the load register. Capture and PWM lanes wrap in the same way.
- R6: In joined down-counting modes, the 32-bit value `{count_o[1],count_o[0]}` decrements once per cycle while enabled. The borrow passes from the low half into the high half, and the prescaler has no effect.
- R7: Joined mode with `mode32_i[1]`=1 selects the real-time counter. The 32-bit count increments only in cycles where `rtc_tick_i` is high. The match flag (bit 2 of lane 0) is set in the cycle after the count becomes equal to the 32-bit match value. No time-out flag is raised in this mode.
- R8: Capture lane (mode 2'b10): the input passes through a two-flop synchronizer. An edge selected by `cap_edge_i` (bit 0 = rising, bit 1 = falling) copies the count into `capture_o` and sets the capture flag (bit 1). The copy is visible three clock edges after the input changes, and it holds the count as it stood after the second of those edges. Edges that are not selected have no effect.
- R9: PWM lane (mode 2'b11): `pwm_o` is high exactly while the lane is enabled and its count is greater than its match value. It is low otherwise, so every reload to a value above the match value raises it again.
- R10: Flags are sticky until a one in `flag_clr_i` clears them. A flag event in the same cycle as a clear wins, and the flag stays set.
- R11: Every time-out event makes `adc_trig_o` high for the following cycle. Repeated time-outs keep it high.
- R12: `en_clr_i` wins over `en_set_i`. In joined mode, the enable controls of lane 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| split_i | input | 1 | 1: two independent lanes, 0: one joined 32-bit counter |
| mode32_i | input | 2 | Joined mode: 00 one-shot, 01 periodic, 1x real-time counter |
| half_mode_i | input | 2x2 | Per-lane mode: 00 one-shot, 01 periodic, 10 capture, 11 PWM |
| en_set_i | input | 2 | Per-lane enable strobe |
| en_clr_i | input | 2 | Per-lane disable strobe |
| load_we_i | input | 2 | Per-lane load write strobe |
| load_val_i | input | 2x16 | Load values |
| match_we_i | input | 2 | Per-lane match write strobe |
| match_val_i | input | 2x16 | Match values |
| pre_we_i | input | 2 | Per-lane prescale write strobe |
| pre_val_i | input | 2x8 | Prescale values |
| cap_edge_i | input | 2x2 | Capture edge select per lane |
| cap_in_i | input | 2 | Asynchronous capture inputs |
| rtc_tick_i | input | 1 | Synchronous once-per-second strobe |
| flag_clr_i | input | 2x3 | Write-one-to-clear flag strobes |
| flag_o | output | 2x3 | Sticky flags: bit0 time-out, bit1 capture, bit2 match |
| count_o | output | 2x16 | Lane counts |
| capture_o | output | 2x16 | Captured counts |
| pwm_o | output | 2 | PWM outputs |
| running_o | output | 2 | Lane enabled |
| adc_trig_o | output | 1 | Conversion start pulse |

## Verification
The hardest situation to reach is the joined periodic reload after the low half has wrapped through its full range. It needs a borrow into the high half and then a 32-bit zero before the reload. The stimulus loads 0x0001_0002 and checks the value just past the borrow. It then lets the counter run for the full 65,539 cycles to the reload. The second hard case is a flag clear that arrives in the same cycle as a new event. A periodic lane loaded with zero times out on every cycle, and the clear strobe is issued while it does. Random one-shot and periodic runs with random loads, prescales and run lengths are compared against closed-form counts and time-out totals.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int NLANE = 2;
  localparam int NFLAG = 3;
  localparam int FL_TIMEOUT = 0;
  localparam int FL_CAPTURE = 1;
  localparam int FL_MATCH   = 2;

  typedef enum logic [1:0] {
    HM_ONESHOT  = 2'b00,
    HM_PERIODIC = 2'b01,
    HM_CAPTURE  = 2'b10,
    HM_PWM      = 2'b11
  } half_mode_e;

  localparam logic [1:0] WM_ONESHOT  = 2'b00;
  localparam logic [1:0] WM_PERIODIC = 2'b01;
endpackage

// File: rtl/gpt_edge.sv
module gpt_edge #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       d_i,
  input  logic [1:0] sel_i,
  output logic       hit_o
);
  logic [SYNC:0] sh;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC-1:0], d_i};
  end

  assign rise  = sh[SYNC-1] & ~sh[SYNC];
  assign fall  = ~sh[SYNC-1] & sh[SYNC];
  assign hit_o = (sel_i[0] & rise) | (sel_i[1] & fall);
endmodule

// File: rtl/gpt_flags.sv
module gpt_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= (q_o & ~clr_i) | set_i;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(q_o) & ~$past(clr_i)) & ~q_o) == '0)); // R10
  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i))); // R10
endmodule

// File: rtl/gpt_lane.sv
module gpt_lane #(
  parameter int W    = 16,
  parameter int PW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_we_i,
  input  logic [W-1:0]  load_val_i,
  input  logic          match_we_i,
  input  logic [W-1:0]  match_val_i,
  input  logic          pre_we_i,
  input  logic [PW-1:0] pre_val_i,
  input  logic          pre_en_i,
  input  logic          run_i,
  input  logic          dec_i,
  input  logic          inc_i,
  input  logic          reload_i,
  input  logic          cap_en_i,
  input  logic [1:0]    cap_sel_i,
  input  logic          cap_in_i,
  output logic [W-1:0]  cnt_o,
  output logic [W-1:0]  match_o,
  output logic [W-1:0]  cap_o,
  output logic          tick_o,
  output logic          cap_evt_o
);
  logic [W-1:0]  load_q;
  logic [PW-1:0] pre_q, pre_cnt;
  logic          edge_hit;

  assign tick_o = run_i && (!pre_en_i || pre_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q  <= '0;
      match_o <= '0;
      pre_q   <= '0;
    end else begin
      if (load_we_i)  load_q  <= load_val_i;
      if (match_we_i) match_o <= match_val_i;
      if (pre_we_i)   pre_q   <= pre_val_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 pre_cnt <= '0;
    else if (pre_we_i)          pre_cnt <= pre_val_i;
    else if (load_we_i)         pre_cnt <= pre_q;
    else if (run_i && pre_en_i) pre_cnt <= (pre_cnt == '0) ? pre_q : pre_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_o <= '0;
    else if (load_we_i) cnt_o <= load_val_i;
    else if (reload_i)  cnt_o <= load_q;
    else if (dec_i)     cnt_o <= cnt_o - 1'b1;
    else if (inc_i)     cnt_o <= cnt_o + 1'b1;
  end

  gpt_edge #(.SYNC(SYNC)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cap_in_i),
    .sel_i (cap_sel_i),
    .hit_o (edge_hit)
  );

  assign cap_evt_o = cap_en_i && edge_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)         cap_o <= '0;
    else if (cap_evt_o) cap_o <= cnt_o;
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load_we_i |=> cnt_o == $past(load_val_i)); // R2
  AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_we_i && !reload_i) |=> cnt_o == $past(cnt_o) - 1'b1); // R3
  AST_CAP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt_o |=> cap_o == $past(cnt_o)); // R8
endmodule

// File: rtl/gp_timer.sv
module gp_timer
  import gpt_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int PRE_W  = 8,
  parameter int SYNC   = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           split_i,
  input  logic [1:0]                     mode32_i,
  input  logic [NLANE-1:0][1:0]          half_mode_i,
  input  logic [NLANE-1:0]               en_set_i,
  input  logic [NLANE-1:0]               en_clr_i,
  input  logic [NLANE-1:0]               load_we_i,
  input  logic [NLANE-1:0][HALF_W-1:0]   load_val_i,
  input  logic [NLANE-1:0]               match_we_i,
  input  logic [NLANE-1:0][HALF_W-1:0]   match_val_i,
  input  logic [NLANE-1:0]               pre_we_i,
  input  logic [NLANE-1:0][PRE_W-1:0]    pre_val_i,
  input  logic [NLANE-1:0][1:0]          cap_edge_i,
  input  logic [NLANE-1:0]               cap_in_i,
  input  logic                           rtc_tick_i,
  input  logic [NLANE-1:0][NFLAG-1:0]    flag_clr_i,
  output logic [NLANE-1:0][NFLAG-1:0]    flag_o,
  output logic [NLANE-1:0][HALF_W-1:0]   count_o,
  output logic [NLANE-1:0][HALF_W-1:0]   capture_o,
  output logic [NLANE-1:0]               pwm_o,
  output logic [NLANE-1:0]               running_o,
  output logic                           adc_trig_o
);
  localparam int WIDE_W = 2 * HALF_W;

  logic [NLANE-1:0] en_q, tick, zero, dec, inc, reload, stop, to_evt;
  logic [NLANE-1:0] cap_en, cap_evt, lane_run, lane_ld_we, lane_mt_we;
  logic [NLANE-1:0][HALF_W-1:0] match_q;
  logic [WIDE_W-1:0] cnt32, match32, cnt32_nx;
  logic wide_down, wide_zero, rtc_step, match_evt;
  half_mode_e hmode [NLANE];

  always_comb begin
    for (int h = 0; h < NLANE; h++) begin
      hmode[h]      = half_mode_e'(half_mode_i[h]);
      zero[h]       = (count_o[h] == '0);
      dec[h]        = 1'b0;
      inc[h]        = 1'b0;
      reload[h]     = 1'b0;
      stop[h]       = 1'b0;
      to_evt[h]     = 1'b0;
      cap_en[h]     = 1'b0;
      lane_run[h]   = 1'b0;
      lane_ld_we[h] = load_we_i[0];
      lane_mt_we[h] = match_we_i[0];
    end
    cnt32     = {count_o[1], count_o[0]};
    match32   = {match_q[1], match_q[0]};
    cnt32_nx  = cnt32 + 1'b1;
    wide_down = !mode32_i[1];
    wide_zero = (cnt32 == '0);
    rtc_step  = !split_i && mode32_i[1] && en_q[0] && rtc_tick_i;
    match_evt = rtc_step && (cnt32_nx == match32);
    if (split_i) begin
      for (int h = 0; h < NLANE; h++) begin
        lane_run[h]   = en_q[h];
        to_evt[h]     = tick[h] && zero[h];
        dec[h]        = tick[h] && !zero[h];
        reload[h]     = to_evt[h] && (hmode[h] != HM_ONESHOT);
        stop[h]       = to_evt[h] && (hmode[h] == HM_ONESHOT);
        cap_en[h]     = (hmode[h] == HM_CAPTURE);
        lane_ld_we[h] = load_we_i[h];
        lane_mt_we[h] = match_we_i[h];
      end
    end else begin
      lane_run[0] = en_q[0] && wide_down;
      to_evt[0]   = tick[0] && wide_zero;
      dec[0]      = tick[0] && !wide_zero;
      dec[1]      = dec[0] && zero[0];
      reload[0]   = to_evt[0] && (mode32_i == WM_PERIODIC);
      reload[1]   = reload[0];
      stop[0]     = to_evt[0] && (mode32_i == WM_ONESHOT);
      inc[0]      = rtc_step;
      inc[1]      = rtc_step && (count_o[0] == '1);
    end
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic allow_set;
    logic [NFLAG-1:0] fset;

    assign allow_set = split_i || (g == 0);

    always_ff @(posedge clk) begin
      if (!rst_n)                        en_q[g] <= 1'b0;
      else if (en_clr_i[g])              en_q[g] <= 1'b0;
      else if (en_set_i[g] && allow_set) en_q[g] <= 1'b1;
      else if (stop[g])                  en_q[g] <= 1'b0;
    end

    gpt_lane #(.W(HALF_W), .PW(PRE_W), .SYNC(SYNC)) u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_we_i   (lane_ld_we[g]),
      .load_val_i  (load_val_i[g]),
      .match_we_i  (lane_mt_we[g]),
      .match_val_i (match_val_i[g]),
      .pre_we_i    (pre_we_i[g]),
      .pre_val_i   (pre_val_i[g]),
      .pre_en_i    (split_i),
      .run_i       (lane_run[g]),
      .dec_i       (dec[g]),
      .inc_i       (inc[g]),
      .reload_i    (reload[g]),
      .cap_en_i    (cap_en[g]),
      .cap_sel_i   (cap_edge_i[g]),
      .cap_in_i    (cap_in_i[g]),
      .cnt_o       (count_o[g]),
      .match_o     (match_q[g]),
      .cap_o       (capture_o[g]),
      .tick_o      (tick[g]),
      .cap_evt_o   (cap_evt[g])
    );

    always_comb begin
      fset             = '0;
      fset[FL_TIMEOUT] = to_evt[g];
      fset[FL_CAPTURE] = cap_evt[g];
      fset[FL_MATCH]   = (g == 0) ? match_evt : 1'b0;
    end

    gpt_flags #(.N(NFLAG)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (fset),
      .clr_i (flag_clr_i[g]),
      .q_o   (flag_o[g])
    );

    assign running_o[g] = en_q[g] && allow_set;
    assign pwm_o[g]     = split_i && (hmode[g] == HM_PWM) && en_q[g]
                          && (count_o[g] > match_q[g]);

    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      (stop[g] && !en_set_i[g]) |=> !running_o[g] && zero[g]); // R4
    AST_CAP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[g] |=> flag_o[g][FL_CAPTURE]); // R8
  end

  always_ff @(posedge clk) begin
    if (!rst_n) adc_trig_o <= 1'b0;
    else        adc_trig_o <= |to_evt;
  end

  AST_TRIG_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig_o |-> (flag_o[0][FL_TIMEOUT] || flag_o[1][FL_TIMEOUT])); // R11
  AST_RTC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!split_i && mode32_i[1] && !rtc_tick_i && !load_we_i[0]) |=> $stable(count_o)); // R7
  AST_CLR_BEATS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr_i[0] |=> !running_o[0]); // R12
endmodule

// File: tb/gp_timer_bench.sv
module gp_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic split = 1'b1;
  logic [1:0] mode32 = '0;
  logic [1:0][1:0] half_mode = '0;
  logic [1:0] en_set = '0, en_clr = '0, load_we = '0, match_we = '0, pre_we = '0;
  logic [1:0][15:0] load_val = '0, match_val = '0;
  logic [1:0][7:0] pre_val = '0;
  logic [1:0][1:0] cap_edge = '0;
  logic [1:0] cap_in = '0;
  logic rtc_tick = 1'b0;
  logic [1:0][2:0] flag_clr = '0;
  logic [1:0][2:0] flag_o;
  logic [1:0][15:0] count_o, capture_o;
  logic [1:0] pwm_o, running_o;
  logic adc_trig_o;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  gp_timer u_gp_timer (
    .clk(clk), .rst_n(rst_n), .split_i(split), .mode32_i(mode32),
    .half_mode_i(half_mode), .en_set_i(en_set), .en_clr_i(en_clr),
    .load_we_i(load_we), .load_val_i(load_val), .match_we_i(match_we),
    .match_val_i(match_val), .pre_we_i(pre_we), .pre_val_i(pre_val),
    .cap_edge_i(cap_edge), .cap_in_i(cap_in), .rtc_tick_i(rtc_tick),
    .flag_clr_i(flag_clr), .flag_o(flag_o), .count_o(count_o),
    .capture_o(capture_o), .pwm_o(pwm_o), .running_o(running_o),
    .adc_trig_o(adc_trig_o)
  );

  function automatic int exp_cnt(int ld, int p, int k, bit per);
    int t;
    t = k / (p + 1);
    if (per) return ld - (t % (ld + 1));
    return (t >= ld) ? 0 : ld - t;
  endfunction

  function automatic int exp_to(int ld, int p, int k, bit per);
    int t;
    t = k / (p + 1);
    if (per) return t / (ld + 1);
    return (t > ld) ? 1 : 0;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick_n(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr_load(int h, logic [15:0] v);
    load_val[h] = v; load_we[h] = 1'b1; @(negedge clk); load_we[h] = 1'b0;
  endtask
  task automatic wr_load32(logic [31:0] v);
    load_val[1] = v[31:16]; load_val[0] = v[15:0];
    load_we[0] = 1'b1; @(negedge clk); load_we[0] = 1'b0;
  endtask
  task automatic wr_match(int h, logic [15:0] v);
    match_val[h] = v; match_we[h] = 1'b1; @(negedge clk); match_we[h] = 1'b0;
  endtask
  task automatic wr_match32(logic [31:0] v);
    match_val[1] = v[31:16]; match_val[0] = v[15:0];
    match_we[0] = 1'b1; @(negedge clk); match_we[0] = 1'b0;
  endtask
  task automatic wr_pre(int h, logic [7:0] v);
    pre_val[h] = v; pre_we[h] = 1'b1; @(negedge clk); pre_we[h] = 1'b0;
  endtask
  task automatic go(int h);
    en_set[h] = 1'b1; @(negedge clk); en_set[h] = 1'b0;
  endtask
  task automatic stop_all();
    en_clr = 2'b11; @(negedge clk); en_clr = 2'b00;
  endtask
  task automatic clr_flags();
    flag_clr = '1; @(negedge clk); flag_clr = '0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int h, ld, p, k;
    bit per;
    void'($urandom(32'd20240611));
    tick_n(3);
    rst_n = 1'b1;
    tick_n(1);
    // R1 reset state
    chk("R1", "count", count_o, 0);
    chk("R1", "flags", flag_o, 0);
    chk("R1", "capture", capture_o, 0);
    chk("R1", "pwm/run", {pwm_o, running_o}, 0);
    chk("R1", "trig", adc_trig_o, 0);

    // R2 load in split and joined mode
    wr_load(0, 16'h1234);
    chk("R2", "split load", count_o[0], 16'h1234);
    split = 1'b0;
    wr_load32(32'hABCD_0042);
    chk("R2", "joined load", {count_o[1], count_o[0]}, 32'hABCD_0042);
    split = 1'b1;

    // R3 R4 R5 random one-shot / periodic runs
    for (int it = 0; it < 24; it++) begin
      h   = $urandom_range(1, 0);
      ld  = $urandom_range(30, 1);
      p   = $urandom_range(3, 0);
      per = 1'($urandom_range(1, 0));
      k   = $urandom_range(150, 1);
      stop_all(); clr_flags();
      half_mode[h] = per ? 2'b01 : 2'b00;
      wr_pre(h, 8'(p)); wr_load(h, 16'(ld)); go(h); tick_n(k);
      chk("R3", "random count", count_o[h], exp_cnt(ld, p, k, per));
      chk(per ? "R5" : "R4", "random timeout flag", flag_o[h][0], exp_to(ld, p, k, per) > 0);
      chk("R4", "random running", running_o[h], per ? 1 : (exp_to(ld, p, k, per) == 0));
    end

    // R4 R11 R10 directed one-shot
    stop_all(); clr_flags();
    half_mode[0] = 2'b00;
    wr_pre(0, 0); wr_load(0, 2); go(0); tick_n(2);
    chk("R4", "at zero", {count_o[0], running_o[0], flag_o[0][0], adc_trig_o}, {16'd0, 1'b1, 1'b0, 1'b0});
    tick_n(1);
    chk("R4", "stopped", {count_o[0], running_o[0], flag_o[0][0]}, {16'd0, 1'b0, 1'b1});
    chk("R11", "trig pulse", adc_trig_o, 1);
    tick_n(1);
    chk("R11", "trig drops", adc_trig_o, 0);
    chk("R10", "flag sticky", flag_o[0][0], 1);
    clr_flags();
    chk("R10", "w1c clears", flag_o[0][0], 0);

    // R10 set beats clear, R11 continuous trigger
    half_mode[0] = 2'b01;
    wr_load(0, 0); go(0); tick_n(2); clr_flags();
    chk("R10", "set wins over clear", flag_o[0][0], 1);
    chk("R11", "trig held", adc_trig_o, 1);
    stop_all(); clr_flags();

    // R6 joined periodic with borrow, prescaler ignored
    split = 1'b0; mode32 = 2'b01;
    wr_pre(0, 3); wr_load32(32'h0001_0002); go(0); tick_n(3);
    chk("R6", "borrow", {count_o[1], count_o[0]}, 32'h0000_FFFF);
    tick_n(65536);
    chk("R6", "wide reload", {count_o[1], count_o[0]}, 32'h0001_0002);
    chk("R5", "wide timeout flag", flag_o[0][0], 1);
    stop_all(); clr_flags();
    mode32 = 2'b00;
    wr_load32(32'd5); go(0); tick_n(6);
    chk("R6", "wide oneshot", {count_o[1], count_o[0], running_o[0], flag_o[0][0]}, {32'd0, 1'b0, 1'b1});

    // R12 lane 1 controls ignored in joined mode
    wr_load32(32'h0007_0007);
    go(1); tick_n(3);
    chk("R12", "lane1 set ignored", {running_o[1], count_o[1], count_o[0]}, {1'b0, 32'h0007_0007});

    // R7 real-time counter
    clr_flags();
    mode32 = 2'b10;
    wr_load32(32'h0000_FFFE); wr_match32(32'h0001_0001); go(0); tick_n(5);
    chk("R7", "no tick holds", {count_o[1], count_o[0]}, 32'h0000_FFFE);
    for (int t = 0; t < 3; t++) begin
      rtc_tick = 1'b1; @(negedge clk); rtc_tick = 1'b0;
      if (t == 1) chk("R7", "no early match", flag_o[0][2], 0);
      tick_n(2);
    end
    chk("R7", "count with carry", {count_o[1], count_o[0]}, 32'h0001_0001);
    chk("R7", "match flag", flag_o[0][2], 1);
    chk("R7", "no timeout", flag_o[0][0], 0);
    stop_all(); clr_flags();

    // R8 capture
    split = 1'b1; mode32 = 2'b00;
    half_mode[1] = 2'b10; cap_edge[1] = 2'b01;
    wr_pre(1, 0); wr_load(1, 100);
    cap_in[1] = 1'b1; tick_n(3);
    chk("R8", "rising capture", {capture_o[1], flag_o[1][1]}, {16'd100, 1'b1});
    clr_flags(); wr_load(1, 50);
    cap_in[1] = 1'b0; tick_n(3);
    chk("R8", "falling ignored", {capture_o[1], flag_o[1][1]}, {16'd100, 1'b0});
    cap_edge[1] = 2'b11;
    cap_in[1] = 1'b1; tick_n(3);
    chk("R8", "both edges", {capture_o[1], flag_o[1][1]}, {16'd50, 1'b1});
    clr_flags(); wr_load(1, 200); go(1); tick_n(2);
    cap_in[1] = 1'b0; tick_n(3);
    chk("R8", "running capture", capture_o[1], 196);
    stop_all(); clr_flags();

    // R9 PWM
    half_mode[0] = 2'b11;
    wr_pre(0, 1); wr_load(0, 8); wr_match(0, 5); go(0);
    for (int kk = 0; kk <= 40; kk++) begin
      chk("R9", "pwm level", pwm_o[0], exp_cnt(8, 1, kk, 1) > 5);
      tick_n(1);
    end
    stop_all(); wr_load(0, 9);
    chk("R9", "pwm off when stopped", pwm_o[0], 0);

    // R12 clear beats set
    en_set[0] = 1'b1; en_clr[0] = 1'b1; @(negedge clk); en_set[0] = 1'b0; en_clr[0] = 1'b0;
    chk("R12", "clear beats set", running_o[0], 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule